// File: doc/BRIEF.md
# Conditional Add/Subtract/Select Unit with Overflow Flags

This block is a one-stage datapath that performs an addition, a subtraction or a two-way select, gated by a test on a third operand. The test checks whether a control word is zero or nonzero. A 3-bit operation code picks one of six operations. When the test passes, an arithmetic operation writes its sum or difference. When the test fails, the first operand passes through unchanged, and the computed value is thrown away.

Besides the data result, the block keeps four status bits:

- a signed-overflow bit;
- an "advance overflow" bit, which is set when the top two result bits differ;
- a sticky copy of each of those two bits.

The sticky copies build up across many operations until they are explicitly cleared. The block is meant to sit beside a register file. The caller presents the operands with a valid strobe and collects the result one clock later.

Top module: `cond_arith_unit`

## Requirements
- R1: While `rst_n` is low, the result and all four status bits are 0.
- R2: The operation code is split into fields. `op_i[2:1]` selects the kind of operation: 00 is add, 01 is subtract, 10 is select and 11 is reserved. `op_i[0]` selects the condition: with 0 the condition holds when `ctl_i` is nonzero, and with 1 it holds when `ctl_i` equals zero.
- R3: For an add whose condition holds, `result_o` is `opa_i + opb_i` modulo 2^32. `ovf_o` is 1 exactly when the two operands have the same sign and the sum has the other sign.
- R4: For a subtract whose condition holds, `result_o` is `opa_i - opb_i` modulo 2^32. `ovf_o` is bit 31 of `((result ^ opa_i) & (opa_i ^ opb_i))`.
- R5: For an add or subtract whose condition holds, `aovf_o` is `result[31] ^ result[30]`.
- R6: For an add or subtract whose condition fails, `result_o` becomes `opa_i`, and none of the four status bits changes.
- R7: Every add or subtract whose condition holds ORs the new `ovf_o` into `sovf_o` and the new `aovf_o` into `saovf_o`. The sticky bits never clear except by reset or by `clr_sticky_i`.
- R8: A select writes `opa_i` when its condition holds and `opb_i` otherwise. A select leaves all four status bits unchanged.
- R9: `clr_sticky_i` clears both sticky bits at the clock edge, whether or not `valid_i` is high. If an add or subtract with a passing condition lands on the same edge, its new flags are still ORed into the cleared sticky bits.
- R10: When `valid_i` is low, or when the operation code is reserved (6 or 7), the result register and the non-sticky flags keep their values.
- R11: The result and the flags are registered. They change at the rising edge where `valid_i` is high and are visible from then on (one-cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (kind in bits 2:1, condition polarity in bit 0) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| ctl_i | input | 32 | Control word tested against zero |
| clr_sticky_i | input | 1 | Clears both sticky flags |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Overflow of the last passing add or subtract |
| sovf_o | output | 1 | Sticky overflow |
| aovf_o | output | 1 | Advance overflow of the last passing add or subtract |
| saovf_o | output | 1 | Sticky advance overflow |

## Verification
The assertions assume that `valid_i`, `op_i`, `clr_sticky_i` and the operands carry known values on every clock edge after reset. They also assume that the inputs hold steady across each edge, so that `$past` of an operand is the value the design captured. The stimulus changes inputs only on falling edges and never leaves them undefined. It drives reserved operation codes and idle cycles with arbitrary operand values, so the hold properties are exercised with live data on the buses. Both values of the condition are reached on purpose: the control word is forced to zero in a good share of the random cycles.

// File: rtl/cau_pkg.sv
package cau_pkg;
  localparam int unsigned CAU_OP_W = 3;

  // bits [2:1]: operation kind, bit [0]: condition polarity (1 = "is zero")
  typedef enum logic [1:0] {
    KIND_ADD = 2'b00,
    KIND_SUB = 2'b01,
    KIND_SEL = 2'b10,
    KIND_RSV = 2'b11
  } cau_kind_e;

  typedef struct packed {
    logic ovf;
    logic aovf;
  } cau_flag_pair_t;
endpackage

// File: rtl/cau_cond.sv
module cau_cond #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] ctl_i,
  input  logic         on_zero_i,
  output logic         hit_o
);
  logic is_zero;

  always_comb begin
    is_zero = (ctl_i == '0);
    hit_o   = on_zero_i ? is_zero : !is_zero;
  end
endmodule

// File: rtl/cau_addsub.sv
module cau_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         aovf_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] res_x_a;
  logic [W-1:0] a_x_b;
  logic [W-1:0] ovf_vec;

  always_comb begin
    sum_o   = sub_i ? (a_i - b_i) : (a_i + b_i);
    res_x_a = sum_o ^ a_i;
    a_x_b   = a_i ^ b_i;
    // subtract overflows when operand signs differ, add when they match
    ovf_vec = sub_i ? (res_x_a & a_x_b) : (res_x_a & ~a_x_b);
    ovf_o   = ovf_vec[MSB];
    aovf_o  = sum_o[MSB] ^ sum_o[MSB-1];
  end
endmodule

// File: rtl/cau_flags.sv
module cau_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic ovf_i,
  input  logic aovf_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic sovf_o,
  output logic aovf_o,
  output logic saovf_o
);
  logic ovf_q, sovf_q, aovf_q, saovf_q;
  logic ovf_d, sovf_d, aovf_d, saovf_d;
  logic flag_en;

  always_comb begin
    flag_en = upd_i || clr_i;
    ovf_d   = upd_i ? ovf_i  : ovf_q;
    aovf_d  = upd_i ? aovf_i : aovf_q;
    sovf_d  = (sovf_q  && !clr_i) || (upd_i && ovf_i);
    saovf_d = (saovf_q && !clr_i) || (upd_i && aovf_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      sovf_q  <= 1'b0;
      aovf_q  <= 1'b0;
      saovf_q <= 1'b0;
    end else if (flag_en) begin
      ovf_q   <= ovf_d;
      sovf_q  <= sovf_d;
      aovf_q  <= aovf_d;
      saovf_q <= saovf_d;
    end
  end

  assign ovf_o   = ovf_q;
  assign sovf_o  = sovf_q;
  assign aovf_o  = aovf_q;
  assign saovf_o = saovf_q;

  // R7: sticky bits only fall through the clear input
  p_sticky_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && sovf_q) |=> sovf_q);
  p_sticky_akeep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && saovf_q) |=> saovf_q);
  // R7: a fresh flag is always reflected in its sticky copy
  p_sticky_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> ((!ovf_q || sovf_q) && (!aovf_q || saovf_q)));
  // R6/R8/R10: without an update the live flags hold
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> ($stable(ovf_q) && $stable(aovf_q)));
  // R9: clear with no update leaves both sticky bits low
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !upd_i) |=> (!sovf_q && !saovf_q));
endmodule

// File: rtl/cond_arith_unit.sv
module cond_arith_unit
  import cau_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [CAU_OP_W-1:0] op_i,
  input  logic [W-1:0]        opa_i,
  input  logic [W-1:0]        opb_i,
  input  logic [W-1:0]        ctl_i,
  input  logic                clr_sticky_i,
  output logic [W-1:0]        result_o,
  output logic                ovf_o,
  output logic                sovf_o,
  output logic                aovf_o,
  output logic                saovf_o
);
  cau_kind_e      kind;
  logic           hit;
  logic [W-1:0]   sum;
  cau_flag_pair_t fresh;
  logic           is_arith;
  logic           flag_upd;
  logic           res_en;
  logic [W-1:0]   res_d;
  logic [W-1:0]   res_q;

  assign kind = cau_kind_e'(op_i[2:1]);

  cau_cond #(.W(W)) cond_i (
    .ctl_i     (ctl_i),
    .on_zero_i (op_i[0]),
    .hit_o     (hit)
  );

  cau_addsub #(.W(W)) addsub_i (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sub_i  (kind == KIND_SUB),
    .sum_o  (sum),
    .ovf_o  (fresh.ovf),
    .aovf_o (fresh.aovf)
  );

  always_comb begin
    is_arith = (kind == KIND_ADD) || (kind == KIND_SUB);
    flag_upd = valid_i && is_arith && hit;
    res_en   = valid_i && (kind != KIND_RSV);
    unique case (kind)
      KIND_ADD, KIND_SUB: res_d = hit ? sum : opa_i;
      KIND_SEL:           res_d = hit ? opa_i : opb_i;
      default:            res_d = res_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  cau_flags flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (flag_upd),
    .ovf_i   (fresh.ovf),
    .aovf_i  (fresh.aovf),
    .clr_i   (clr_sticky_i),
    .ovf_o   (ovf_o),
    .sovf_o  (sovf_o),
    .aovf_o  (aovf_o),
    .saovf_o (saovf_o)
  );

  assign result_o = res_q;

  // R6: failing arithmetic passes the first operand through
  p_fail_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_arith && !hit) |=> (result_o == $past(opa_i)));
  // R8: select never touches the live flags
  p_select_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind == KIND_SEL) |=> ($stable(ovf_o) && $stable(aovf_o)));
  // R10: idle or reserved cycles keep the result
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || kind == KIND_RSV) |=> $stable(result_o));
  // R2: exactly one of the two polarities passes for a given control word
  p_polarity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && kind == KIND_SEL && ctl_i == '0) |=>
      (result_o == (($past(op_i[0])) ? $past(opa_i) : $past(opb_i))));
endmodule

// File: tb/cond_arith_unit_tb_top.sv
module cond_arith_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [31:0] opa_i, opb_i, ctl_i;
  logic        clr_sticky_i;
  logic [31:0] result_o;
  logic        ovf_o, sovf_o, aovf_o, saovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_res;
  logic        m_ovf, m_sovf, m_aovf, m_saovf;
  string       cur_tag;

  cond_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .ctl_i(ctl_i), .clr_sticky_i(clr_sticky_i),
    .result_o(result_o), .ovf_o(ovf_o), .sovf_o(sovf_o),
    .aovf_o(aovf_o), .saovf_o(saovf_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "result", result_o, m_res);
    chk(tag, "ovf", {31'd0, ovf_o}, {31'd0, m_ovf});
    chk(tag, "sovf", {31'd0, sovf_o}, {31'd0, m_sovf});
    chk(tag, "aovf", {31'd0, aovf_o}, {31'd0, m_aovf});
    chk(tag, "saovf", {31'd0, saovf_o}, {31'd0, m_saovf});
  endtask

  task automatic model(input logic v, input logic [2:0] op,
                       input logic [31:0] a, b, c, input logic clr);
    logic [31:0] r;
    bit hit;
    hit = op[0] ? (c == 0) : (c != 0);
    if (clr) begin
      m_sovf = 1'b0;
      m_saovf = 1'b0;
    end
    if (v) begin
      case (op[2:1])
        2'b00, 2'b01: begin
          if (hit) begin
            if (op[1]) begin
              r = a - b;
              m_ovf = ($signed(a) < 0) != ($signed(b) < 0) && (r[31] != a[31]);
            end else begin
              r = a + b;
              m_ovf = (a[31] == b[31]) && (r[31] != a[31]);
            end
            m_aovf = r[31] != r[30];
            m_res = r;
            if (m_ovf) m_sovf = 1'b1;
            if (m_aovf) m_saovf = 1'b1;
          end else begin
            m_res = a;
          end
        end
        2'b10: m_res = hit ? a : b;
        default: ;
      endcase
    end
  endtask

  // one cycle: check what the previous edge produced, then present new inputs
  task automatic step(input logic v, input logic [2:0] op,
                      input logic [31:0] a, b, c, input logic clr,
                      input string tag);
    @(negedge clk);
    compare_all(cur_tag);
    valid_i = v; op_i = op; opa_i = a; opb_i = b; ctl_i = c;
    clr_sticky_i = clr;
    model(v, op, a, b, c, clr);
    cur_tag = tag;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    valid_i = 0; op_i = 0; opa_i = 0; opb_i = 0; ctl_i = 0; clr_sticky_i = 0;
    m_res = 0; m_ovf = 0; m_sovf = 0; m_aovf = 0; m_saovf = 0;
    cur_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    cur_tag = "R1";

    // R3 add paths: plain, signed overflow, wrap
    step(1, 3'd0, 32'd5, 32'd7, 32'd1, 0, "R3");
    step(1, 3'd0, 32'h7FFF_FFFF, 32'd1, 32'hFF, 0, "R3");
    step(1, 3'd0, 32'hFFFF_FFFF, 32'd1, 32'h8000_0000, 0, "R3");
    // R4 subtract paths
    step(1, 3'd2, 32'h8000_0000, 32'd1, 32'd3, 0, "R4");
    step(1, 3'd2, 32'd10, 32'd3, 32'd3, 0, "R4");
    step(1, 3'd3, 32'd0, 32'h8000_0000, 32'd0, 0, "R4");
    // R5 advance overflow without signed overflow
    step(1, 3'd0, 32'h2000_0000, 32'h2000_0000, 32'd1, 0, "R5");
    step(1, 3'd1, 32'hC000_0000, 32'h0, 32'd0, 0, "R5");
    // R2/R6 failing conditions pass opa, flags hold
    step(1, 3'd0, 32'h1234_5678, 32'h7FFF_FFFF, 32'd0, 0, "R6");
    step(1, 3'd3, 32'hAAAA_0000, 32'h5555, 32'd9, 0, "R2");
    // R8 select both ways and polarities
    step(1, 3'd4, 32'h1111_1111, 32'h2222_2222, 32'd4, 0, "R8");
    step(1, 3'd4, 32'h1111_1111, 32'h2222_2222, 32'd0, 0, "R8");
    step(1, 3'd5, 32'h3333_3333, 32'h4444_4444, 32'd0, 0, "R2");
    step(1, 3'd5, 32'h3333_3333, 32'h4444_4444, 32'd7, 0, "R8");
    // R10 idle and reserved codes
    step(0, 3'd0, 32'h7FFF_FFFF, 32'd1, 32'd1, 0, "R10");
    step(1, 3'd6, 32'hDEAD_BEEF, 32'd1, 32'd1, 0, "R10");
    step(1, 3'd7, 32'hDEAD_BEEF, 32'd1, 32'd0, 0, "R10");
    // R9 clear alone, with idle valid, and coinciding with an overflow
    step(0, 3'd0, 32'd0, 32'd0, 32'd0, 1, "R9");
    step(1, 3'd0, 32'h7FFF_FFFF, 32'd1, 32'd1, 0, "R7");
    step(1, 3'd0, 32'h7FFF_FFFF, 32'd1, 32'd1, 1, "R9");
    step(1, 3'd0, 32'd1, 32'd1, 32'd1, 0, "R7");
    step(1, 3'd4, 32'd1, 32'd2, 32'd1, 1, "R9");
    // R11 back-to-back results each visible one edge later
    step(1, 3'd0, 32'd100, 32'd1, 32'd1, 0, "R11");
    step(1, 3'd2, 32'd100, 32'd1, 32'd1, 0, "R11");

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a, b, c;
      logic [2:0] op;
      a = $urandom();
      b = $urandom();
      c = ($urandom() % 3 == 0) ? 32'd0 : $urandom();
      if ($urandom() % 4 == 0) a = {a[31], {31{~a[31]}}};
      op = 3'($urandom() % 8);
      step(($urandom() % 8) != 0, op, a, b, c, ($urandom() % 16) == 0,
           op[2:1] == 2'b01 ? "R4" : (op[2:1] == 2'b00 ? "R3" :
           (op[2:1] == 2'b10 ? "R8" : "R10")));
    end

    // async reset mid-run brings everything back to zero
    @(negedge clk);
    compare_all(cur_tag);
    rst_n = 1'b0;
    m_res = 0; m_ovf = 0; m_sovf = 0; m_aovf = 0; m_saovf = 0;
    #1;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    valid_i = 0;
    cur_tag = "R1";
    step(0, 3'd0, 32'd0, 32'd0, 32'd0, 0, "R10");
    @(negedge clk);
    compare_all(cur_tag);
    finish_run();
  end
endmodule